// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block connects a clocked host to an external asynchronous static RAM holding 256K words of 16 bits. The host raises a request with an address, a direction, write data and a per-byte lane mask, holds it, and waits for a one-cycle acknowledge. The controller then produces the memory's active-low chip select, output enable, write enable and per-lane byte selects, and a split data bus made of an output value, an output-enable and an input value.

Every phase of an access is a whole number of clock cycles, computed when the block is built from the clock period and the memory's minimum times in picoseconds. Each minimum is rounded up and never drops below one cycle. The write pulse is lengthened when the setup, pulse and hold phases together would fall short of the minimum write cycle or of the address-to-end-of-write time. Writes reach only the lanes named in the mask. The address is held for the whole access. A read that follows a write waits through a turnaround gap, with the bus released and output enable high, before the memory is allowed to drive.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset and whenever chip select is high, write enable, output enable and both byte selects are high, the data output enable is low and the acknowledge is low.
- R2: A write changes only the memory lanes whose mask bit is 1. Mask bit 0 selects data bits 7:0 through byte select bit 0. Mask bit 1 selects bits 15:8 through byte select bit 1. A lane whose mask bit is 0 keeps its old content.
- R3: In a write, chip select, address and byte selects are active for AS cycles before write enable falls. Write enable then stays low for exactly WP cycles, and the data output is driven during every low cycle and for DH cycles after it rises.
- R4: The memory address does not change while write enable is low, nor in the cycle in which write enable returns high. Chip select stays low in that cycle.
- R5: A read holds chip select and output enable low for ACC cycles and captures the input on the last of them. A lane whose mask bit is 0 is returned as zero.
- R6: The data output enable is never high while output enable is low. A read accepted while the last bus-driving access was a write first spends TURN cycles with chip select and output enable high.
- R7: The acknowledge is high for exactly one cycle per accepted request, and read data is valid from that cycle until the next read completes.
- R8: Address, data, mask and direction are taken in the cycle a request is accepted. Changes to them before the acknowledge have no effect.
- R9: A request with an all-zero mask is acknowledged one cycle after acceptance, leaves write enable and output enable high, changes no memory word, and leaves the read data unchanged.
- R10: Latency from acceptance to acknowledge is AS+WP+DH+1 for a write, ACC+1 for a read, and TURN+ACC+1 for a read after a write. With the default 5000 ps clock these phase counts are AS=1, WP=2, DH=1, ACC=3 and TURN=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_req | input | 1 | Request, held until acknowledge |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 18 | Word address |
| host_wdata | input | 16 | Write data |
| host_mask | input | 2 | Lane mask, bit 0 = bits 7:0 |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 16 | Read data |
| mem_addr | output | 18 | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_bs_n | output | 2 | Byte selects, active low, bit 0 = lower lane |
| mem_dq_out | output | 16 | Data driven toward memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 16 | Data returned by memory |

## Verification
The memory model in the bench returns junk until output enable has been low for the full access window, so a controller that captures early reads garbage. It also replays writes only for the selected lanes, which exposes masks wired to the wrong lane or ignored. A read-after-write latency check catches a missing turnaround gap. Address scrambling after acceptance shows a controller that tracks live inputs, because data would land at the wrong word. Zero-mask requests catch a controller that pulses a strobe with no lane selected, and the pulse-width and post-rise address checks catch a shortened pulse or an address that moves before the strobe closes.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WSETUP,
      ST_WPULSE,
      ST_WHOLD,
      ST_TURN,
      ST_RACC,
      ST_DONE
   } st_e;

   // Whole cycles covering t_ps, never below one.
   function automatic int cyc_of(input int t_ps, input int clk_ps);
      int c;
      c = (t_ps + clk_ps - 1) / clk_ps;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             last
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)               cnt_q <= '0;
      else if (load)         cnt_q <= load_val;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign last = (cnt_q == '0);

endmodule

// File: rtl/sram_lane_gate.sv
module sram_lane_gate #(
   parameter int LANES  = 2,
   parameter int LANE_W = 8,
   localparam int DW    = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             act,
   input  logic [LANES-1:0] mask,
   input  logic             capture,
   input  logic [DW-1:0]    dq_in,
   output logic [LANES-1:0] bs_n,
   output logic [DW-1:0]    rdata
);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign bs_n[i] = ~(act & mask[i]);

      always_ff @(posedge clk) begin
         if (rst)
            rdata[i*LANE_W +: LANE_W] <= '0;
         else if (capture)
            rdata[i*LANE_W +: LANE_W] <= mask[i] ? dq_in[i*LANE_W +: LANE_W] : '0;
      end
   end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
   import sram_lane_pkg::*;
#(
   parameter int ADDR_W    = 18,
   parameter int DATA_W    = 16,
   parameter int CLK_PS    = 5000,
   parameter int T_AS_PS   = 0,
   parameter int T_WP_PS   = 10000,
   parameter int T_AW_PS   = 10000,
   parameter int T_WC_PS   = 15000,
   parameter int T_DH_PS   = 0,
   parameter int T_ACC_PS  = 15000,
   parameter int T_TURN_PS = 7000,
   localparam int LANES    = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              host_req,
   input  logic              host_we,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic [LANES-1:0]  host_mask,
   output logic              host_ack,
   output logic [DATA_W-1:0] host_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_cs_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [LANES-1:0]  mem_bs_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);

   localparam int AS_CYC   = cyc_of(T_AS_PS, CLK_PS);
   localparam int DH_CYC   = cyc_of(T_DH_PS, CLK_PS);
   localparam int WP_WC    = cyc_of(T_WC_PS, CLK_PS) - AS_CYC - DH_CYC;
   localparam int WP_AW    = cyc_of(T_AW_PS, CLK_PS) - AS_CYC;
   localparam int WP_CYC   = max2(cyc_of(T_WP_PS, CLK_PS), max2(WP_WC, WP_AW));
   localparam int ACC_CYC  = cyc_of(T_ACC_PS, CLK_PS);
   localparam int TURN_CYC = cyc_of(T_TURN_PS, CLK_PS);
   localparam int MAX_CYC  = max2(max2(AS_CYC, DH_CYC), max2(WP_CYC, max2(ACC_CYC, TURN_CYC)));
   localparam int CNT_W    = $clog2(MAX_CYC + 1);

   if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_width
      $error("DATA_W must be a positive multiple of 8");
   end
   if (CLK_PS <= 0) begin : g_bad_clk
      $error("CLK_PS must be positive");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("ADDR_W must be at least 1");
   end

   st_e               st_q, st_d;
   logic              tmr_load, tmr_last;
   logic [CNT_W-1:0]  tmr_val;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [LANES-1:0]  mask_q;
   logic              wrote_q;
   logic              cs_n_q, oe_n_q, we_n_q, dq_oe_q, act_q, ack_q;
   logic              accept, capture;

   assign accept  = (st_q == ST_IDLE) && host_req;
   assign capture = (st_q == ST_RACC) && tmr_last;

   always_comb begin
      st_d     = st_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (st_q)
         ST_IDLE: if (host_req) begin
            tmr_load = 1'b1;
            if (host_mask == '0) begin
               st_d = ST_DONE;
            end else if (host_we) begin
               st_d    = ST_WSETUP;
               tmr_val = CNT_W'(AS_CYC - 1);
            end else if (wrote_q) begin
               st_d    = ST_TURN;
               tmr_val = CNT_W'(TURN_CYC - 1);
            end else begin
               st_d    = ST_RACC;
               tmr_val = CNT_W'(ACC_CYC - 1);
            end
         end
         ST_WSETUP: if (tmr_last) begin
            st_d = ST_WPULSE; tmr_load = 1'b1; tmr_val = CNT_W'(WP_CYC - 1);
         end
         ST_WPULSE: if (tmr_last) begin
            st_d = ST_WHOLD; tmr_load = 1'b1; tmr_val = CNT_W'(DH_CYC - 1);
         end
         ST_WHOLD: if (tmr_last) st_d = ST_DONE;
         ST_TURN: if (tmr_last) begin
            st_d = ST_RACC; tmr_load = 1'b1; tmr_val = CNT_W'(ACC_CYC - 1);
         end
         ST_RACC: if (tmr_last) st_d = ST_DONE;
         ST_DONE: st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q    <= ST_IDLE;
         cs_n_q  <= 1'b1;
         oe_n_q  <= 1'b1;
         we_n_q  <= 1'b1;
         dq_oe_q <= 1'b0;
         act_q   <= 1'b0;
         ack_q   <= 1'b0;
         wrote_q <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
         mask_q  <= '0;
      end else begin
         st_q    <= st_d;
         act_q   <= st_d inside {ST_WSETUP, ST_WPULSE, ST_WHOLD, ST_RACC};
         cs_n_q  <= !(st_d inside {ST_WSETUP, ST_WPULSE, ST_WHOLD, ST_RACC});
         we_n_q  <= (st_d != ST_WPULSE);
         oe_n_q  <= (st_d != ST_RACC);
         dq_oe_q <= st_d inside {ST_WPULSE, ST_WHOLD};
         ack_q   <= (st_d == ST_DONE);
         if (accept) begin
            addr_q  <= host_addr;
            wdata_q <= host_wdata;
            mask_q  <= host_mask;
         end
         if (st_q == ST_WHOLD && tmr_last)     wrote_q <= 1'b1;
         else if (st_q == ST_TURN && tmr_last) wrote_q <= 1'b0;
      end
   end

   sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst      (rst),
      .load     (tmr_load),
      .load_val (tmr_val),
      .last     (tmr_last)
   );

   sram_lane_gate #(.LANES(LANES), .LANE_W(8)) u_lanes (
      .clk     (clk),
      .rst     (rst),
      .act     (act_q),
      .mask    (mask_q),
      .capture (capture),
      .dq_in   (mem_dq_in),
      .bs_n    (mem_bs_n),
      .rdata   (host_rdata)
   );

   assign host_ack   = ack_q;
   assign mem_addr   = addr_q;
   assign mem_cs_n   = cs_n_q;
   assign mem_oe_n   = oe_n_q;
   assign mem_we_n   = we_n_q;
   assign mem_dq_out = wdata_q;
   assign mem_dq_oe  = dq_oe_q;

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
      mem_cs_n |-> (mem_we_n && mem_oe_n && (&mem_bs_n) && !mem_dq_oe));

   a_r3_drive_in_pulse: assert property (@(posedge clk) disable iff (rst)
      !mem_we_n |-> mem_dq_oe);

   a_r4_addr_in_pulse: assert property (@(posedge clk) disable iff (rst)
      !mem_we_n |-> $stable(mem_addr));

   a_r4_addr_after_rise: assert property (@(posedge clk) disable iff (rst)
      $rose(mem_we_n) |-> ($stable(mem_addr) && !mem_cs_n));

   a_r6_no_fight: assert property (@(posedge clk) disable iff (rst)
      mem_dq_oe |-> mem_oe_n);

   a_r7_ack_single: assert property (@(posedge clk) disable iff (rst)
      host_ack |=> !host_ack);

   a_r9_lane_needed: assert property (@(posedge clk) disable iff (rst)
      (!mem_we_n || !mem_oe_n) |-> !(&mem_bs_n));

endmodule

// File: tb/sram_lane_ctrl_bench.sv
module sram_lane_ctrl_bench;

   localparam int CLK_P = 10;

   function automatic int c1(input int t, input int p);
      int c;
      c = (t + p - 1) / p;
      return (c < 1) ? 1 : c;
   endfunction

   localparam int AS   = c1(0, 5000);
   localparam int DH   = c1(0, 5000);
   localparam int WPA  = c1(10000, 5000);
   localparam int WPB  = c1(15000, 5000) - AS - DH;
   localparam int WPC  = c1(10000, 5000) - AS;
   localparam int WP   = (WPA > WPB) ? ((WPA > WPC) ? WPA : WPC) : ((WPB > WPC) ? WPB : WPC);
   localparam int ACC  = c1(15000, 5000);
   localparam int TURN = c1(7000, 5000);

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        host_req = 1'b0, host_we = 1'b0;
   logic [17:0] host_addr = '0;
   logic [15:0] host_wdata = '0;
   logic [1:0]  host_mask = '0;
   logic        host_ack;
   logic [15:0] host_rdata;
   logic [17:0] mem_addr;
   logic        mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
   logic [1:0]  mem_bs_n;
   logic [15:0] mem_dq_out, mem_dq_in;

   always #(CLK_P/2) clk = ~clk;

   sram_lane_ctrl u_sram_lane_ctrl (
      .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_mask(host_mask),
      .host_ack(host_ack), .host_rdata(host_rdata), .mem_addr(mem_addr),
      .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
      .mem_bs_n(mem_bs_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
      .mem_dq_in(mem_dq_in)
   );

   int n_chk = 0, n_err = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // ---------------- external memory model ----------------
   logic [15:0] smem [int];
   int          oe_cnt = 0, we_run = 0, cs_run = 0;
   logic [17:0] pulse_addr = '0;

   function automatic logic [15:0] srd(input int a);
      return smem.exists(a) ? smem[a] : 16'h0000;
   endfunction

   always_comb begin
      logic [15:0] w;
      w = srd(int'(mem_addr));
      for (int i = 0; i < 2; i++) begin
         mem_dq_in[i*8 +: 8] = (!mem_cs_n && !mem_oe_n && !mem_bs_n[i] && oe_cnt >= ACC)
                               ? w[i*8 +: 8] : 8'hA5;
      end
   end

   always @(negedge clk) begin
      if (!rst) begin
         if (mem_cs_n && (!mem_we_n || !mem_oe_n || mem_bs_n != 2'b11 || mem_dq_oe))
            chk(1'b0, "R1 strobes active with chip select high", {mem_we_n, mem_oe_n, mem_bs_n, mem_dq_oe}, 32'h1E);
         if (mem_dq_oe && !mem_oe_n)
            chk(1'b0, "R6 bus driven while output enable low", 1, 0);
         if (!mem_cs_n && !mem_we_n) begin
            if (!mem_dq_oe) chk(1'b0, "R3 data not driven in pulse", 0, 1);
            if (we_run == 0) begin
               pulse_addr = mem_addr;
               chk(cs_run >= AS, "R3 setup cycles before write enable", cs_run, AS);
            end else if (mem_addr != pulse_addr) begin
               chk(1'b0, "R4 address moved in pulse", mem_addr, pulse_addr);
            end
            begin
               logic [15:0] w;
               w = srd(int'(mem_addr));
               for (int i = 0; i < 2; i++)
                  if (!mem_bs_n[i]) w[i*8 +: 8] = mem_dq_out[i*8 +: 8];
               smem[int'(mem_addr)] = w;
            end
            we_run++;
         end else if (we_run != 0) begin
            chk(we_run == WP, "R3 write pulse width", we_run, WP);
            chk(mem_addr == pulse_addr && !mem_cs_n, "R4 address/cs after rise", mem_addr, pulse_addr);
            chk(mem_dq_oe, "R3 data hold after rise", mem_dq_oe, 1);
            we_run = 0;
         end
         oe_cnt = (!mem_cs_n && !mem_oe_n) ? oe_cnt + 1 : 0;
         cs_run = (!mem_cs_n) ? cs_run + 1 : 0;
      end
   end

   // ---------------- scoreboard ----------------
   typedef struct { bit is_rd; logic [15:0] exp; } item_t;
   item_t       sbq[$];
   logic [15:0] ref_mem [int];
   logic [15:0] last_rd = '0;
   bit          prev_wr = 1'b0;
   logic        ack_d = 1'b0;

   function automatic logic [15:0] rrd(input int a);
      return ref_mem.exists(a) ? ref_mem[a] : 16'h0000;
   endfunction

   always @(negedge clk) begin
      if (!rst) begin
         if (host_ack && ack_d) chk(1'b0, "R7 acknowledge longer than one cycle", 1, 0);
         if (host_ack) begin
            if (sbq.size() == 0) begin
               chk(1'b0, "R7 acknowledge without request", 0, 1);
            end else begin
               item_t it;
               it = sbq.pop_front();
               if (it.is_rd) chk(host_rdata == it.exp, "R5 R2 read data", host_rdata, it.exp);
            end
         end
         ack_d = host_ack;
      end
   end

   task automatic access(input bit we, input logic [17:0] a, input logic [15:0] d,
                         input logic [1:0] m, input bit scramble, input string tag);
      item_t it;
      int    lat = 0, strobes = 0, exp_lat;
      if (m == 2'b00) begin
         exp_lat = 1;
         it.is_rd = !we; it.exp = last_rd;
      end else if (we) begin
         logic [15:0] w;
         w = rrd(int'(a));
         for (int i = 0; i < 2; i++) if (m[i]) w[i*8 +: 8] = d[i*8 +: 8];
         ref_mem[int'(a)] = w;
         exp_lat = AS + WP + DH + 1;
         prev_wr = 1'b1;
         it.is_rd = 1'b0; it.exp = '0;
      end else begin
         logic [15:0] w, r;
         w = rrd(int'(a));
         r = '0;
         for (int i = 0; i < 2; i++) if (m[i]) r[i*8 +: 8] = w[i*8 +: 8];
         exp_lat = (prev_wr ? TURN : 0) + ACC + 1;
         prev_wr = 1'b0;
         last_rd = r;
         it.is_rd = 1'b1; it.exp = r;
      end
      sbq.push_back(it);
      @(negedge clk);
      host_we = we; host_addr = a; host_wdata = d; host_mask = m; host_req = 1'b1;
      while (1) begin
         @(posedge clk);
         lat++;
         @(negedge clk);
         if (scramble && lat == 1) begin
            host_addr = ~a; host_wdata = ~d; host_mask = ~m; host_we = ~we;
         end
         if (!mem_we_n || !mem_oe_n) strobes++;
         if (host_ack || lat > 60) break;
      end
      host_req = 1'b0;
      chk(lat == exp_lat, {"R10 latency ", tag}, lat, exp_lat);
      if (m == 2'b00) chk(strobes == 0, {"R9 strobes on empty mask ", tag}, strobes, 0);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      // R1: reset state
      chk({mem_cs_n, mem_we_n, mem_oe_n, mem_bs_n, mem_dq_oe, host_ack} == 7'b1111100,
          "R1 reset outputs", {mem_cs_n, mem_we_n, mem_oe_n, mem_bs_n, mem_dq_oe, host_ack}, 7'b1111100);

      // R2 full-word write, R6 turnaround read
      access(1'b1, 18'h00010, 16'h1234, 2'b11, 1'b0, "wr full");
      access(1'b0, 18'h00010, 16'h0000, 2'b11, 1'b0, "rd after wr");
      access(1'b0, 18'h00010, 16'h0000, 2'b11, 1'b0, "rd plain");
      // R2 lane masks
      access(1'b1, 18'h00010, 16'hABCD, 2'b01, 1'b0, "wr low lane");
      access(1'b0, 18'h00010, 16'h0000, 2'b11, 1'b0, "rd low lane");
      access(1'b1, 18'h00010, 16'h9900, 2'b10, 1'b0, "wr high lane");
      // R5 zero fill of unselected lanes
      access(1'b0, 18'h00010, 16'h0000, 2'b01, 1'b0, "rd mask 01");
      access(1'b0, 18'h00010, 16'h0000, 2'b10, 1'b0, "rd mask 10");
      // R9 empty masks
      access(1'b1, 18'h00010, 16'hFFFF, 2'b00, 1'b0, "wr empty");
      access(1'b0, 18'h00010, 16'h0000, 2'b00, 1'b0, "rd empty");
      access(1'b0, 18'h00010, 16'h0000, 2'b11, 1'b0, "rd after empty");
      // R8 inputs scrambled after acceptance
      access(1'b1, 18'h3FFFF, 16'h5A5A, 2'b11, 1'b1, "wr scrambled top addr");
      access(1'b0, 18'h3FFFF, 16'h0000, 2'b11, 1'b1, "rd scrambled top addr");
      access(1'b0, 18'h00000, 16'h0000, 2'b11, 1'b0, "rd unscrambled target");
      // back-to-back writes then reads
      access(1'b1, 18'h00000, 16'hC3C3, 2'b11, 1'b0, "wr addr 0");
      access(1'b1, 18'h00001, 16'h0F0F, 2'b11, 1'b0, "wr addr 1");
      access(1'b0, 18'h00000, 16'h0000, 2'b11, 1'b0, "rd addr 0");
      access(1'b0, 18'h00001, 16'h0000, 2'b11, 1'b0, "rd addr 1");
      repeat (4) @(negedge clk);
      chk(sbq.size() == 0, "R7 every request acknowledged", sbq.size(), 0);
      chk(mem_cs_n && mem_we_n && mem_oe_n, "R1 idle after traffic", {mem_cs_n, mem_we_n, mem_oe_n}, 3'b111);
      finish_run();
   end

endmodule